// File: doc/BRIEF.md
# Shared-Port Fetch Stall Controller

This block steers a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) whose instruction fetch and data access share one memory port. Every cycle it decides who owns the port. An instruction sitting in the memory stage that needs the port always wins. On such a clash the fetch and the decode stage freeze, and an empty slot is pushed into execute. The execute, memory and write-back stages keep moving, so the access that caused the clash finishes.

Each in-flight slot carries two bits: whether it holds an instruction, and whether that instruction touches memory. The fetch side presents a request together with the memory-use bit of the instruction it wants to fetch. The controller returns the fetch enable, the decode enable, the execute-bubble strobe, the data-port grant and a strobe for each instruction leaving write-back. When every instruction uses memory, instructions complete in pairs: the first finishes four cycles after the first fetch, and the spacing after that alternates between one cycle and three cycles. This halves the long-run throughput.

Top module: `hz_stall_ctrl`

## Requirements
- R1: While reset is held, `retire` and `data_port` stay low and the pipeline is empty when reset is released.
- R2: `if_en` is high exactly when `fetch_req` is high and the memory-stage slot does not hold an instruction whose memory-use bit is set. A slot whose memory-use bit is clear never blocks fetch.
- R3: With no stall in its path, an instruction fetched in cycle c drives `retire` high in cycle c+4. A stream of non-memory instructions retires one per cycle.
- R4: In a clash cycle, `if_en` and `id_en` are low and `ex_bubble` is high in that same cycle. In every other cycle, `id_en` is high and `ex_bubble` is low.
- R5: The execute, memory and write-back stages advance during a stall. `data_port` is high exactly when the memory stage holds a memory-using instruction, and two cycles after any `ex_bubble` it is low.
- R6: `ex_bubble` is never high for more than two consecutive cycles.
- R7: If every fetched instruction uses memory and `fetch_req` stays high from an empty pipeline, with the first fetch in cycle 0, the i-th `retire` pulse lands in cycle Ti. Here T1 = 4, Ti = Ti-1 + 1 for even i, and Ti = Ti-1 + 3 for odd i.
- R8: A cycle with `fetch_req` low grants no fetch and sends an empty slot into decode. That slot never produces a `retire` pulse.
- R9: Every granted fetch produces exactly one `retire` pulse. An instruction held in decode is neither lost nor duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch side wants the port this cycle |
| fetch_mem | input | 1 | Memory-use bit of the instruction being fetched |
| if_en | output | 1 | Fetch granted; program counter advances |
| id_en | output | 1 | Decode stage may load; low holds it |
| ex_bubble | output | 1 | Empty slot is pushed into execute |
| data_port | output | 1 | Memory stage owns the shared port |
| retire | output | 1 | A valid instruction leaves write-back |

## Verification
The bound checker watches four things on every cycle: that a memory-stage access always beats a fetch, that the decode hold and the execute bubble always come together on a clash, that a bubble frees the data port two cycles later, and that stall runs stay at two cycles or fewer. Retirement timing is checked only by the bench's scenarios. This covers the four-cycle latency, the paired completion pattern in the all-memory stream, idle fetch cycles that must never retire, and the final balance of fetches against retirements, because each of these depends on a history that spans many cycles.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef struct packed {
    logic valid;
    logic mem;
  } slot_t;

  localparam slot_t EMPTY_SLOT = '{valid: 1'b0, mem: 1'b0};

  // Port clash: fetch wants the port while a memory user sits in the data stage.
  function automatic logic port_clash(input logic req, input slot_t s);
    return req & s.valid & s.mem;
  endfunction

  function automatic slot_t new_slot(input logic mem);
    slot_t s;
    s.valid = 1'b1;
    s.mem   = mem;
    return s;
  endfunction

endpackage

// File: rtl/hz_arbiter.sv
module hz_arbiter
  import hz_pkg::*;
(
  input  logic  fetch_req,
  input  slot_t me_slot,
  output logic  stall,
  output logic  fetch_grant,
  output logic  data_grant
);

  always_comb begin
    data_grant  = me_slot.valid & me_slot.mem;
    stall       = port_clash(fetch_req, me_slot);
    fetch_grant = fetch_req & ~stall;
  end

endmodule

// File: rtl/hz_slot_chain.sv
module hz_slot_chain
  import hz_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int HOLD_SLOTS = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stall,
  input  logic                  fetch_grant,
  input  logic                  fetch_mem,
  output slot_t [SLOTS-1:0]     slots_q
);

  slot_t incoming;
  slot_t [SLOTS-1:0] prev_w;
  slot_t [SLOTS-1:0] next_w;

  always_comb incoming = fetch_grant ? new_slot(fetch_mem) : EMPTY_SLOT;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k == 0) begin : g_head
      assign prev_w[k] = incoming;
    end else begin : g_link
      assign prev_w[k] = slots_q[k-1];
    end

    if (k < HOLD_SLOTS) begin : g_frozen
      assign next_w[k] = stall ? slots_q[k] : prev_w[k];
    end else if (k == HOLD_SLOTS) begin : g_bubble
      assign next_w[k] = stall ? EMPTY_SLOT : prev_w[k];
    end else begin : g_flow
      assign next_w[k] = prev_w[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slots_q[k] <= EMPTY_SLOT;
      else        slots_q[k] <= next_w[k];
    end
  end

endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
#(
  parameter int STAGES    = 5,
  parameter int MEM_STAGE = 3,
  parameter int HOLD_UPTO = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_req,
  input  logic fetch_mem,
  output logic if_en,
  output logic id_en,
  output logic ex_bubble,
  output logic data_port,
  output logic retire
);

  // Slots cover every stage after fetch; stage s lives in slot s-1.
  localparam int SLOTS    = STAGES - 1;
  localparam int MEM_SLOT = MEM_STAGE - 1;

  slot_t [SLOTS-1:0] slots_q;
  slot_t me_slot;
  slot_t wb_slot;
  logic  stall;
  logic  fetch_grant;
  logic  data_grant;

  assign me_slot = slots_q[MEM_SLOT];
  assign wb_slot = slots_q[SLOTS-1];

  hz_arbiter u_arb (
    .fetch_req   (fetch_req),
    .me_slot     (me_slot),
    .stall       (stall),
    .fetch_grant (fetch_grant),
    .data_grant  (data_grant)
  );

  hz_slot_chain #(
    .SLOTS      (SLOTS),
    .HOLD_SLOTS (HOLD_UPTO)
  ) u_chain (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall       (stall),
    .fetch_grant (fetch_grant),
    .fetch_mem   (fetch_mem),
    .slots_q     (slots_q)
  );

  assign if_en     = fetch_grant;
  assign id_en     = ~stall;
  assign ex_bubble = stall;
  assign data_port = data_grant;
  assign retire    = wb_slot.valid;

endmodule

// File: rtl/hz_stall_ctrl_chk.sv
module hz_stall_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic fetch_req,
  input logic if_en,
  input logic id_en,
  input logic ex_bubble,
  input logic data_port
);

  assert_me_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && data_port) |-> !if_en);

  assert_clash_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !if_en) |-> (!id_en && ex_bubble));

  assert_bubble_frees_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |=> ##1 !data_port);

  assert_short_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble ##1 ex_bubble |=> !ex_bubble);

endmodule

bind hz_stall_ctrl hz_stall_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .fetch_req (fetch_req),
  .if_en     (if_en),
  .id_en     (id_en),
  .ex_bubble (ex_bubble),
  .data_port (data_port)
);

// File: tb/hz_stall_ctrl_tb_top.sv
`timescale 1ns/1ps
module hz_stall_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_req = 1'b0;
  logic fetch_mem = 1'b0;
  logic if_en, id_en, ex_bubble, data_port, retire;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int run = 0;
  int fetched = 0;
  int retired = 0;
  bit rec_on = 0;
  bit done = 0;
  int ret_times[$];
  int posq[$];
  bit memq[$];

  always #4 clk = ~clk;

  hz_stall_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_mem(fetch_mem),
    .if_en(if_en), .id_en(id_en), .ex_bubble(ex_bubble),
    .data_port(data_port), .retire(retire)
  );

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b cycle=%0d", what, act, exp, cyc);
    end
  endtask

  task automatic chk_int(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // One cycle: drive, compare against the queue model, then advance the model.
  task automatic step(input bit req, input bit mem);
    bit me_mem, exp_conf, exp_if, exp_ret;
    int np[$];
    bit nm[$];
    @(negedge clk);
    fetch_req = req;
    fetch_mem = mem;
    #1;
    me_mem = 0;
    exp_ret = 0;
    foreach (posq[i]) begin
      if (posq[i] == 3 && memq[i]) me_mem = 1;
      if (posq[i] == 4) exp_ret = 1;
    end
    exp_conf = req && me_mem;
    exp_if = req && !exp_conf;
    chk("R2 fetch grant", if_en, exp_if);
    chk("R4 decode enable", id_en, !exp_conf);
    chk("R4 execute bubble", ex_bubble, exp_conf);
    chk("R5 data port", data_port, me_mem);
    chk("R3 retire", retire, exp_ret);
    if (!req) chk("R8 idle cycle grants nothing", if_en, 1'b0);
    if (ex_bubble) begin
      run++;
      chk("R6 stall run length", run > 2, 1'b0);
    end else begin
      run = 0;
    end
    if (retire) begin
      retired++;
      if (rec_on) ret_times.push_back(cyc);
    end
    if (if_en) fetched++;
    foreach (posq[i]) begin
      if (posq[i] != 4) begin
        np.push_back((exp_conf && posq[i] == 1) ? 1 : posq[i] + 1);
        nm.push_back(memq[i]);
      end
    end
    if (exp_if) begin
      np.push_back(1);
      nm.push_back(mem);
    end
    posq = np;
    memq = nm;
    cyc++;
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) step(1'b0, 1'b0);
  endtask

  initial begin
    // R1: reset holds the pipeline empty even with a fetch pending.
    fetch_req = 1'b1;
    fetch_mem = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 retire in reset", retire, 1'b0);
    chk("R1 data port in reset", data_port, 1'b0);
    fetch_req = 1'b0;
    rst_n = 1'b1;

    // R3: non-memory stream, one retire per cycle after four cycles.
    for (int k = 0; k < 12; k++) step(1'b1, 1'b0);
    drain();

    // R7: all-memory stream from an empty pipeline.
    cyc = 0;
    rec_on = 1;
    for (int k = 0; k < 40; k++) step(1'b1, 1'b1);
    rec_on = 0;
    drain();
    begin
      int t;
      t = 4;
      for (int i = 1; i <= 8; i++) begin
        if (i > 1) t += (i % 2 == 0) ? 1 : 3;
        if (ret_times.size() >= i) chk_int($sformatf("R7 completion cycle of instr %0d", i), ret_times[i-1], t);
        else chk_int("R7 missing completion", 0, t);
      end
    end

    // R8/R2: mixed stream with idle gaps and alternating memory use.
    for (int k = 0; k < 200; k++) step((k % 7) != 3, ((k * 5) % 3) == 0);
    drain();
    for (int k = 0; k < 60; k++) step(1'b1, (k % 4) < 2);
    drain();

    // R9: fetch and retire balance.
    chk_int("R9 retired equals fetched", retired, fetched);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule